// File: doc/BRIEF.md
# Parallel cable link framer

This block carries 56-bit protocol words over a 16-line parallel cable in each direction. Each clock cycle puts one frame on the cable: 13 data lines, a carrier line that separates data frames from control (idle) frames, and a per-frame odd parity line. The sixteenth line is the cable clock, which is outside this block. One word needs five data frames. These give 65 payload bits: the 56 word bits, an 8-bit CRC and one overall parity bit. The transmitter puts at least one idle frame after every word, so the carrier line always drops between words.

The word source offers a word by holding `tx_valid_i` with the data. The framer takes the word by pulsing `tx_read_o` when it is free. On the receive side, the deframer finds word boundaries from carrier transitions. It checks line parity and the word check bits, then offers the word with a status code. The word stays offered until the consumer pulses `rx_read_i`. A word cut short by an early idle is reported as fatal.

Top module: `pcab_framer`

## Requirements
- R1: While `rst_n` is low on a clock edge, the transmit lines go idle (carrier 0, data 0, parity 1), `tx_read_o` is 0 even if a word is offered, and `rx_ready_o`, `rx_word_o` and `rx_status_o` are all 0.
- R2: When a word is offered while the transmitter is free and reset is released, `tx_read_o` is 1 in that cycle and the word is taken on that clock edge.
- R3: After the word is taken, five carrier-1 frames follow in consecutive cycles. The 65-bit payload is {word[55:0], crc[7:0], p}. Frame k (k = 0..4) carries payload bits [64-13k : 52-13k], with the most significant bit on data line 12.
- R4: The CRC uses polynomial x^8+x^2+x+1 with an initial value of 0. It is computed over word bit 55 down to bit 0. The bit p is set so that the whole 65-bit payload has an even number of ones.
- R5: At least one idle frame (carrier 0, data lines 0) follows every word, and `tx_read_o` stays 0 while a carrier-1 frame is on the lines.
- R6: On every transmitted frame, the 13 data bits, the carrier and the parity line together hold an odd number of ones.
- R7: After reset, the receiver ignores carrier-1 frames until it has seen at least one carrier-0 frame.
- R8: Five consecutive carrier-1 frames after an idle make one word. In the cycle after the fifth frame, `rx_ready_o` is 1, `rx_word_o` holds the word and `rx_status_o` is 000 if all checks pass.
- R9: If any of the five frames fails the odd line parity, the status is 001. This code takes priority over 010.
- R10: If every frame passes line parity but the received CRC or the overall payload parity does not match, the status is 010.
- R11: If a carrier-0 frame arrives after one to four carrier-1 frames, the partial word is dropped. In the next cycle `rx_ready_o` is 1, the status is 011 and `rx_word_o` is 0.
- R12: Carrier-1 frames that follow the fifth frame of a word are ignored until the next carrier-0 frame. They change neither the offered word nor its status.
- R13: `rx_ready_o` stays 1 until a clock edge with `rx_read_i` high. A newly completed word replaces the data and status of an unread one and keeps `rx_ready_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid_i | input | 1 | A word is offered for sending |
| tx_word_i | input | 56 | Offered word |
| tx_read_o | output | 1 | Framer takes the offered word on this edge |
| cab_tx_data_o | output | 13 | Outgoing frame data lines |
| cab_tx_carrier_o | output | 1 | Outgoing carrier: 1 data frame, 0 idle |
| cab_tx_parity_o | output | 1 | Outgoing odd parity line |
| cab_rx_data_i | input | 13 | Incoming frame data lines |
| cab_rx_carrier_i | input | 1 | Incoming carrier |
| cab_rx_parity_i | input | 1 | Incoming parity line |
| rx_ready_o | output | 1 | A received word is offered |
| rx_word_o | output | 56 | Received word |
| rx_read_i | input | 1 | Consumer takes the received word |
| rx_status_o | output | 3 | 000 ok, 001 line parity, 010 check bits, 011 cut short |

## Verification
The transmit path is driven with a table of words: all zeros, all ones, a single high bit, a single low bit, an alternating pattern and a mixed pattern. Each emitted frame is compared with a CRC computed separately in the bench. The zero word shows that parity and idle encoding differ. The single-bit words show that the bits land in the right frame positions, and the mixed words exercise the CRC. The same frames are looped back into the receiver, which confirms that the two sides agree. The directed receive frames then separate each status code from the others: a bad line parity, a flipped payload bit with repaired line parity, a flipped overall parity bit, the case where both line parity and check fail, words cut short after one and after three frames, surplus carrier-1 frames, and carrier-1 traffic right after reset.

// File: rtl/pcab_pkg.sv
// Shared types for the parallel cable framer.
// Assumes: one frame per clock; the check field is an 8-bit CRC plus one parity bit.
package pcab_pkg;

    localparam int CRC_W = 8;
    localparam int CHK_W = CRC_W + 1;

    typedef enum logic [2:0] {
        ST_OK       = 3'b000,
        ST_LINE_PAR = 3'b001,
        ST_CHECK    = 3'b010,
        ST_CUT      = 3'b011
    } pcab_status_e;

endpackage

// File: rtl/pcab_crc8.sv
// Combinational CRC-8 over a word, MSB first, initial value 0.
// Assumes: the polynomial's x^8 term is implicit in POLY.
module pcab_crc8 #(
    parameter int          DATA_W = 56,
    parameter logic [7:0]  POLY   = 8'h07
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [7:0]        crc_o
);

    // Bit-serial CRC unrolled over the word
    always_comb begin
        logic [7:0] c;
        c = 8'h00;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (c[7] ^ data_i[i]) c = {c[6:0], 1'b0} ^ POLY;
            else                  c = {c[6:0], 1'b0};
        end
        crc_o = c;
    end

endmodule

// File: rtl/pcab_tx.sv
// Transmit framer: takes an offered word, sends it as NFR carrier-1 frames,
// then at least one idle frame. Outputs are registered.
// Assumes: the word source holds tx_valid_i and the word until tx_read_o.
module pcab_tx
    import pcab_pkg::*;
#(
    parameter int         DATA_W  = 56,
    parameter int         FRAME_W = 13,
    parameter logic [7:0] POLY    = 8'h07
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [DATA_W-1:0]  word_i,
    output logic               read_o,
    output logic [FRAME_W-1:0] data_o,
    output logic               carrier_o,
    output logic               parity_o
);

    localparam int PAY_BITS = DATA_W + CHK_W;
    localparam int NFR      = (PAY_BITS + FRAME_W - 1) / FRAME_W;
    localparam int PAY_W    = NFR * FRAME_W;
    localparam int PAD_W    = PAY_W - PAY_BITS;
    localparam int CNT_W    = $clog2(NFR + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(NFR);

    logic [CRC_W-1:0]   crc;
    logic [PAY_W-1:0]   pay_n;
    logic [PAY_W-1:0]   pay_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sending_q;
    logic [FRAME_W-1:0] head_n;
    logic [FRAME_W-1:0] head_q;

    pcab_crc8 #(.DATA_W(DATA_W), .POLY(POLY)) u_crc (
        .data_i (word_i),
        .crc_o  (crc)
    );

    // Build the payload: word, CRC, even-weight bit, zero pad at the bottom
    always_comb begin
        pay_n  = PAY_W'({word_i, crc, ^{word_i, crc}}) << PAD_W;
        head_n = pay_n[PAY_W-1 -: FRAME_W];
        head_q = pay_q[PAY_W-1 -: FRAME_W];
    end

    // Take a word only when free and out of reset
    assign read_o = rst_n & valid_i & ~sending_q;

    // Frame sequencer and registered cable outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sending_q <= 1'b0;
            cnt_q     <= '0;
            pay_q     <= '0;
            carrier_o <= 1'b0;
            data_o    <= '0;
            parity_o  <= 1'b1;
        end else if (read_o) begin
            sending_q <= 1'b1;
            cnt_q     <= CNT_W'(1);
            pay_q     <= pay_n << FRAME_W;
            carrier_o <= 1'b1;
            data_o    <= head_n;
            parity_o  <= ~^{1'b1, head_n};
        end else if (sending_q && cnt_q != CNT_END) begin
            cnt_q     <= cnt_q + 1'b1;
            pay_q     <= pay_q << FRAME_W;
            carrier_o <= 1'b1;
            data_o    <= head_q;
            parity_o  <= ~^{1'b1, head_q};
        end else begin
            sending_q <= 1'b0;
            cnt_q     <= '0;
            carrier_o <= 1'b0;
            data_o    <= '0;
            parity_o  <= 1'b1;
        end
    end

    // R5
    tx_no_read_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_o |-> !read_o);

    // R2
    tx_read_starts_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_o |=> carrier_o);

    // R5
    tx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_o |-> (data_o == '0));

endmodule

// File: rtl/pcab_rx.sv
// Receive deframer: synchronises on carrier transitions, gathers NFR frames,
// checks line parity and word check bits, and offers the word until read.
// Assumes: cable inputs are already in the clk domain.
module pcab_rx
    import pcab_pkg::*;
#(
    parameter int         DATA_W  = 56,
    parameter int         FRAME_W = 13,
    parameter logic [7:0] POLY    = 8'h07
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] data_i,
    input  logic               carrier_i,
    input  logic               parity_i,
    output logic               ready_o,
    output logic [DATA_W-1:0]  word_o,
    input  logic               read_i,
    output logic [2:0]         status_o
);

    localparam int PAY_BITS = DATA_W + CHK_W;
    localparam int NFR      = (PAY_BITS + FRAME_W - 1) / FRAME_W;
    localparam int PAY_W    = NFR * FRAME_W;
    localparam int SH_W     = (NFR - 1) * FRAME_W;
    localparam int CNT_W    = $clog2(NFR + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NFR - 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(NFR);

    logic [SH_W-1:0]   sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              synced_q;
    logic              perr_q;
    logic              line_bad;
    logic [PAY_W-1:0]  full;
    logic [DATA_W-1:0] rx_word;
    logic [CRC_W-1:0]  rx_crc;
    logic [CRC_W-1:0]  calc_crc;
    logic              chk_bad;
    pcab_status_e      fin_status;

    pcab_crc8 #(.DATA_W(DATA_W), .POLY(POLY)) u_crc (
        .data_i (rx_word),
        .crc_o  (calc_crc)
    );

    // Assemble the candidate payload and judge it
    always_comb begin
        line_bad = ~(^{parity_i, carrier_i, data_i});
        full     = {sh_q, data_i};
        rx_word  = full[PAY_W-1 -: DATA_W];
        rx_crc   = full[PAY_W-1-DATA_W -: CRC_W];
        chk_bad  = (rx_crc != calc_crc) | (^full[PAY_W-1 -: PAY_BITS]);
        if (perr_q || line_bad) fin_status = ST_LINE_PAR;
        else if (chk_bad)       fin_status = ST_CHECK;
        else                    fin_status = ST_OK;
    end

    // Frame gathering, word completion and consumer handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            synced_q <= 1'b0;
            perr_q   <= 1'b0;
            ready_o  <= 1'b0;
            word_o   <= '0;
            status_o <= ST_OK;
        end else begin
            if (read_i) ready_o <= 1'b0;
            if (!carrier_i) begin
                synced_q <= 1'b1;
                cnt_q    <= '0;
                perr_q   <= 1'b0;
                if (cnt_q != '0 && cnt_q != CNT_DONE) begin
                    ready_o  <= 1'b1;
                    word_o   <= '0;
                    status_o <= ST_CUT;
                end
            end else if (synced_q && cnt_q != CNT_DONE) begin
                if (cnt_q == CNT_LAST) begin
                    ready_o  <= 1'b1;
                    word_o   <= rx_word;
                    status_o <= fin_status;
                    cnt_q    <= CNT_DONE;
                end else begin
                    sh_q   <= {sh_q[SH_W-FRAME_W-1:0], data_i};
                    cnt_q  <= cnt_q + 1'b1;
                    perr_q <= perr_q | line_bad;
                end
            end
        end
    end

    // R11
    rx_cut_zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_CUT) |-> (word_o == '0));

    // R7
    rx_ready_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> synced_q);

    // R13
    rx_ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !read_i) |=> ready_o);

    // R12
    rx_surplus_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_DONE && carrier_i) |=> ($stable(word_o) && $stable(status_o)));

endmodule

// File: rtl/pcab_framer.sv
// Top of the parallel cable framer: independent transmit framer and receive
// deframer sharing one clock and reset.
// Assumes: the cable clock line and line drivers are handled outside.
module pcab_framer #(
    parameter int         DATA_W  = 56,
    parameter int         FRAME_W = 13,
    parameter logic [7:0] POLY    = 8'h07
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_valid_i,
    input  logic [DATA_W-1:0]  tx_word_i,
    output logic               tx_read_o,
    output logic [FRAME_W-1:0] cab_tx_data_o,
    output logic               cab_tx_carrier_o,
    output logic               cab_tx_parity_o,
    input  logic [FRAME_W-1:0] cab_rx_data_i,
    input  logic               cab_rx_carrier_i,
    input  logic               cab_rx_parity_i,
    output logic               rx_ready_o,
    output logic [DATA_W-1:0]  rx_word_o,
    input  logic               rx_read_i,
    output logic [2:0]         rx_status_o
);

    pcab_tx #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .POLY(POLY)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (tx_valid_i),
        .word_i    (tx_word_i),
        .read_o    (tx_read_o),
        .data_o    (cab_tx_data_o),
        .carrier_o (cab_tx_carrier_o),
        .parity_o  (cab_tx_parity_o)
    );

    pcab_rx #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .POLY(POLY)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_i    (cab_rx_data_i),
        .carrier_i (cab_rx_carrier_i),
        .parity_i  (cab_rx_parity_i),
        .ready_o   (rx_ready_o),
        .word_o    (rx_word_o),
        .read_i    (rx_read_i),
        .status_o  (rx_status_o)
    );

endmodule

// File: tb/pcab_framer_test.sv
`timescale 1ns/1ps
module pcab_framer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [55:0] tx_word = '0;
    logic        tx_read;
    logic [12:0] tx_dat;
    logic        tx_car, tx_par;
    logic        lb = 1'b0;
    logic [12:0] b_dat = '0;
    logic        b_car = 1'b0, b_par = 1'b1;
    logic [12:0] rx_dat;
    logic        rx_car, rx_par;
    logic        rx_ready;
    logic [55:0] rx_word;
    logic        rx_read = 1'b0;
    logic [2:0]  rx_status;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign rx_dat = lb ? tx_dat : b_dat;
    assign rx_car = lb ? tx_car : b_car;
    assign rx_par = lb ? tx_par : b_par;

    pcab_framer uut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid_i(tx_valid), .tx_word_i(tx_word), .tx_read_o(tx_read),
        .cab_tx_data_o(tx_dat), .cab_tx_carrier_o(tx_car), .cab_tx_parity_o(tx_par),
        .cab_rx_data_i(rx_dat), .cab_rx_carrier_i(rx_car), .cab_rx_parity_i(rx_par),
        .rx_ready_o(rx_ready), .rx_word_o(rx_word), .rx_read_i(rx_read),
        .rx_status_o(rx_status)
    );

    localparam logic [55:0] VECS [0:5] = '{
        56'h00000000000000, 56'hFFFFFFFFFFFFFF, 56'h80000000000000,
        56'hFFFFFFFFFFFFFE, 56'hAAAAAAAAAAAAAA, 56'h0123456789ABCD
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Byte-wise CRC-8, polynomial 0x07, initial 0
    function automatic logic [7:0] ref_crc(input logic [55:0] w);
        logic [7:0] c = 8'h00;
        for (int b = 6; b >= 0; b--) begin
            c ^= w[b*8 +: 8];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [64:0] ref_pay(input logic [55:0] w);
        logic [7:0] c = ref_crc(w);
        return {w, c, ^{w, c}};
    endfunction

    function automatic logic [12:0] ref_frame(input logic [64:0] p, input int k);
        return 13'(p >> (52 - 13 * k));
    endfunction

    // Drive nfr frames of word w on the receive lines, surplus frames, then idle;
    // returns at the negedge where the result is visible.
    task automatic send_rx(input logic [55:0] w, input int nfr, input int bad_k,
                           input int flip, input int extra);
        logic [64:0] p = ref_pay(w);
        if (flip >= 0) p[64 - flip] = ~p[64 - flip];
        for (int k = 0; k < nfr; k++) begin
            @(negedge clk);
            b_car = 1'b1;
            b_dat = ref_frame(p, k);
            b_par = ~^{1'b1, b_dat};
            if (k == bad_k) b_par = ~b_par;
        end
        for (int e = 0; e < extra; e++) begin
            @(negedge clk);
            b_car = 1'b1;
            b_dat = 13'h0A5C ^ 13'(e);
            b_par = ~^{1'b1, b_dat};
        end
        @(negedge clk);
        b_car = 1'b0; b_dat = '0; b_par = 1'b1;
        if (nfr < 5 && nfr > 0) @(negedge clk);
    endtask

    task automatic pulse_read();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog all actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [64:0] p;
        // ---- R1: reset state, with a word offered and carrier-1 traffic ----
        tx_valid = 1'b1; tx_word = 56'h123; b_car = 1'b1; b_dat = 13'h1F0; b_par = ~^{1'b1, 13'h1F0};
        repeat (3) @(negedge clk);
        chk(!tx_read, "R1 tx_read in reset", 64'(tx_read), 0);
        chk({tx_car, tx_dat, tx_par} == {1'b0, 13'h0, 1'b1}, "R1 tx lines idle",
            64'({tx_car, tx_dat, tx_par}), 64'({1'b0, 13'h0, 1'b1}));
        chk({rx_ready, rx_word, rx_status} == '0, "R1 rx outputs", 64'({rx_ready, rx_status}), 0);
        tx_valid = 1'b0;

        // ---- R7: no word before an idle after reset ----
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(!rx_ready, "R7 frames before first idle ignored", 64'(rx_ready), 0);
        @(negedge clk); b_car = 1'b0; b_dat = '0; b_par = 1'b1;
        send_rx(56'h0F0F0F12345678, 5, -1, -1, 0);
        chk(rx_ready && rx_word == 56'h0F0F0F12345678 && rx_status == 3'b000,
            "R8 direct word received ok", 64'({rx_status, rx_word}), 64'({3'b000, 56'h0F0F0F12345678}));
        pulse_read();
        chk(!rx_ready, "R13 read clears ready", 64'(rx_ready), 0);

        // ---- Table: transmit frames (R2..R6) and loopback receive (R8, R13) ----
        lb = 1'b1;
        @(negedge clk);
        for (int v = 0; v < 6; v++) begin
            p = ref_pay(VECS[v]);
            tx_word = VECS[v]; tx_valid = 1'b1;
            #1;
            chk(tx_read, "R2 tx_read when free", 64'(tx_read), 1);
            @(negedge clk);
            tx_valid = 1'b0;
            for (int k = 0; k < 5; k++) begin
                chk(tx_car && tx_dat == ref_frame(p, k), "R3 R4 frame content",
                    64'({tx_car, tx_dat}), 64'({1'b1, ref_frame(p, k)}));
                chk(^{tx_par, tx_car, tx_dat} == 1'b1, "R6 odd line parity",
                    64'({tx_par, tx_car, tx_dat}), 0);
                if (k < 4) @(negedge clk);
            end
            tx_valid = 1'b1;
            #1;
            chk(!tx_read, "R5 no read during last frame", 64'(tx_read), 0);
            @(negedge clk);
            chk(!tx_car && tx_dat == '0 && tx_par, "R5 idle frame after word",
                64'({tx_car, tx_dat, tx_par}), 64'({1'b0, 13'h0, 1'b1}));
            chk(tx_read, "R2 free again after idle", 64'(tx_read), 1);
            tx_valid = 1'b0;
            chk(rx_ready && rx_word == VECS[v] && rx_status == 3'b000,
                "R8 R13 loopback word", 64'({rx_status, rx_word}), 64'({3'b000, VECS[v]}));
        end
        lb = 1'b0;
        @(negedge clk);

        // ---- R9: one frame with a bad line parity ----
        send_rx(56'h00000000000055, 5, 2, -1, 0);
        chk(rx_status == 3'b001, "R9 line parity error", 64'(rx_status), 1);
        // ---- R13: unread word replaced, ready held ----
        chk(rx_ready, "R13 ready held while unread", 64'(rx_ready), 1);
        // ---- R10: flipped word bit, line parity repaired ----
        send_rx(56'h00000000000055, 5, -1, 20, 0);
        chk(rx_ready && rx_status == 3'b010, "R10 check mismatch", 64'(rx_status), 2);
        // ---- R10: flipped overall parity bit ----
        send_rx(56'h3C3C3C3C3C3C3C, 5, -1, 64, 0);
        chk(rx_status == 3'b010, "R10 overall parity mismatch", 64'(rx_status), 2);
        // ---- R9 priority over R10: flip with broken line parity in frame 1 ----
        send_rx(56'h3C3C3C3C3C3C3C, 5, 1, 20, 0);
        chk(rx_status == 3'b001, "R9 priority over check", 64'(rx_status), 1);
        // ---- R11: cut short after three and after one frame ----
        pulse_read();
        send_rx(56'hABCDEF01234567, 3, -1, -1, 0);
        chk(rx_ready && rx_status == 3'b011 && rx_word == '0, "R11 cut after 3",
            64'({rx_ready, rx_status, rx_word}), 64'({1'b1, 3'b011, 56'h0}));
        pulse_read();
        send_rx(56'hABCDEF01234567, 1, -1, -1, 0);
        chk(rx_ready && rx_status == 3'b011, "R11 cut after 1",
            64'({rx_ready, rx_status}), 64'({1'b1, 3'b011}));
        // ---- R12: surplus carrier-1 frames ignored ----
        pulse_read();
        send_rx(56'h5555AAAA5555AA, 5, -1, -1, 3);
        chk(rx_ready && rx_status == 3'b000 && rx_word == 56'h5555AAAA5555AA,
            "R12 surplus frames ignored", 64'({rx_status, rx_word}), 64'({3'b000, 56'h5555AAAA5555AA}));
        @(negedge clk);
        chk(rx_status == 3'b000 && rx_word == 56'h5555AAAA5555AA, "R12 no cut after surplus",
            64'({rx_status, rx_word}), 64'({3'b000, 56'h5555AAAA5555AA}));
        finish_run();
    end

endmodule